// File: doc/BRIEF.md
# Serial-Programmed Channel Setting Controller

This block sits on each channel board and turns short ASCII text commands into settings for the channel's timing and analog stages. Six settings live in external nonvolatile parts that are programmed over a serial link: three 8-bit switch parts (walk width, gate width, integration constant) and three digital potentiometers (fine gain, pole-zero, discriminator level). Two further 2-bit registers choose which internal signal each of two four-input monitor multiplexers passes to the viewing lines.

When reset is released, the block reads all six stored values back over the serial link and drives them onto its parameter outputs, so the channel comes up with its saved settings. After that, a command addressed to this channel either rewrites one setting or asks for its current value. The reply is two hex characters on a byte-wide transmit stream. The channel address comes from strap inputs. Commands that name another channel, or that are not well formed, leave every setting untouched.

The design has three parts. A character-level parser state machine (`nvpc_parser`) checks the text. A serial shift engine (`nvpc_serial`) runs one read or one write of one part. A control state machine in the top module sequences the power-up load, writes, monitor selects and readback.

Top module: `nvparam_cmd_ctrl`

Parser states: PS_ADR_HI, PS_ADR_LO, PS_LETTER, PS_DAT_HI, PS_DAT_LO, PS_WAIT_CR, PS_SKIP.
- A carriage return moves the parser from any state to PS_ADR_HI.
- Each expected character moves it one state forward.
- Any unexpected character moves it to PS_SKIP.

Serial engine states: SS_IDLE → SS_LOW → SS_HIGH, then either SS_HIGH → SS_LOW for the next bit or SS_HIGH → SS_DONE after bit 7, then SS_DONE → SS_IDLE.

Control states:
- CS_BOOT_GO ↔ CS_BOOT_WAIT, once for each of the six parts, then → CS_IDLE.
- CS_IDLE → CS_WR_WAIT → CS_IDLE for a write.
- CS_IDLE → CS_TX_HI → CS_TX_LO → CS_IDLE for a readback.

## Requirements
- R1: While reset is held, every parameter output and both monitor selects are 0, `tx_valid` is 0, every bit of `nv_cs_n` is 1 and `busy` is 1.
- R2: After reset, the block reads the six parts in index order 0 to 5 with `nv_rd` high. The index mapping is walk=0, gate=1, integration=2, fine gain=3, pole-zero=4, discriminator=5. Each value read is placed on its parameter output, and then `busy` falls.
- R3: A command is a sequence of bytes:
  - two uppercase hex characters giving the 8-bit channel address, high nibble first;
  - one letter naming the target: W, G, I, F, Z, D, or M/N for monitor A/B;
  - for a write, two uppercase hex data characters, high nibble first;
  - carriage return 0x0D.
- R4: A write to a part holds `nv_cs_n[index]` low and sends the 8 data bits MSB first on `nv_sdo`. Each bit is valid while `nv_sclk` is high, and at most one chip select is low at a time. The parameter output takes the new value once the shift has finished.
- R5: A command containing any unexpected character is discarded up to the next carriage return. Unexpected characters include a lowercase character, an unknown letter, a non-hex digit, too few digits and too many digits. A discarded command causes no serial traffic and no change.
- R6: A command whose address differs from `my_addr` causes no write, no register change and no reply.
- R7: A write to M or N with a value from 00 to 03 updates `mon_sel_a` or `mon_sel_b` without serial traffic. A larger value is dropped.
- R8: `busy` is high from the acceptance of a write until its shift completes, and also during power-up load and readback. Any command that completes while `busy` is high is dropped.
- R9: A read command (address, letter, carriage return) returns the current value as two uppercase hex ASCII bytes, high nibble first, on `tx_data` in consecutive cycles with `tx_valid` high. A read of M or N returns 00 to 03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; release starts the power-up load |
| my_addr | input | 8 | Strapped channel address |
| rx_data | input | 8 | Received command byte |
| rx_valid | input | 1 | `rx_data` holds a byte this cycle |
| tx_data | output | 8 | Readback character |
| tx_valid | output | 1 | `tx_data` holds a character this cycle |
| nv_sclk | output | 1 | Serial clock to the nonvolatile parts |
| nv_sdo | output | 1 | Serial data to the parts |
| nv_sdi | input | 1 | Serial data from the parts |
| nv_cs_n | output | 6 | Active-low chip select, one per part, bit = parameter index |
| nv_rd | output | 1 | High while the current transfer is a read |
| busy | output | 1 | Controller is not idle |
| walk_w | output | 8 | Walk width setting |
| gate_w | output | 8 | Gate width setting |
| integ_k | output | 8 | Integration constant setting |
| fine_gain | output | 8 | Fine gain potentiometer setting |
| pole_zero | output | 8 | Pole-zero potentiometer setting |
| disc_lvl | output | 8 | Discriminator level potentiometer setting |
| mon_sel_a | output | 2 | Monitor multiplexer A select |
| mon_sel_b | output | 2 | Monitor multiplexer B select |

## Verification
Well-formed writes go to every one of the six parts with distinct bit patterns. A write is told apart from a read because the memory model commits only non-read transfers, and the order of the bits is confirmed because the model rebuilds each byte MSB first. Near-miss strings test whether the parser rejects on character class and length rather than only on the terminator: a lowercase address, an unknown letter, a bad digit, one digit too few and one too many. Commands that are correct except for the address test whether the filter is applied before any action. Two writes sent back to back test whether a command that lands during a shift is dropped instead of queued.

// File: rtl/nvpc_pkg.sv
package nvpc_pkg;

    localparam int NUM_NV = 6;
    localparam logic [7:0] ASC_CR = 8'h0D;

    localparam logic [2:0] IX_WALK  = 3'd0;
    localparam logic [2:0] IX_GATE  = 3'd1;
    localparam logic [2:0] IX_INTEG = 3'd2;
    localparam logic [2:0] IX_FINE  = 3'd3;
    localparam logic [2:0] IX_PZ    = 3'd4;
    localparam logic [2:0] IX_DISC  = 3'd5;
    localparam logic [2:0] IX_MONA  = 3'd6;
    localparam logic [2:0] IX_MONB  = 3'd7;

    function automatic logic is_hex(input logic [7:0] c);
        return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46);
    endfunction

    function automatic logic [3:0] hex_nib(input logic [7:0] c);
        if (c <= 8'h39) return c[3:0];
        else            return c[3:0] + 4'd9;
    endfunction

    function automatic logic [7:0] nib_hex(input logic [3:0] n);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        else           return 8'h37 + {4'h0, n};
    endfunction

    function automatic logic is_target(input logic [7:0] c);
        case (c)
            "W", "G", "I", "F", "Z", "D", "M", "N": return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [2:0] target_idx(input logic [7:0] c);
        case (c)
            "W": return IX_WALK;
            "G": return IX_GATE;
            "I": return IX_INTEG;
            "F": return IX_FINE;
            "Z": return IX_PZ;
            "D": return IX_DISC;
            "M": return IX_MONA;
            default: return IX_MONB;
        endcase
    endfunction

endpackage

// File: rtl/nvpc_parser.sv
module nvpc_parser
    import nvpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rx_data,
    input  logic       rx_valid,
    output logic       cmd_valid,
    output logic       cmd_rd,
    output logic [7:0] cmd_addr,
    output logic [2:0] cmd_idx,
    output logic [7:0] cmd_data
);

    typedef enum logic [2:0] {
        PS_ADR_HI, PS_ADR_LO, PS_LETTER, PS_DAT_HI, PS_DAT_LO, PS_WAIT_CR, PS_SKIP
    } pst_e;

    pst_e st, st_nx;
    logic is_cr;

    assign is_cr = (rx_data == ASC_CR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PS_ADR_HI;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (rx_valid) begin
            if (is_cr) begin
                st_nx = PS_ADR_HI;
            end else begin
                unique case (st)
                    PS_ADR_HI:  st_nx = is_hex(rx_data)    ? PS_ADR_LO  : PS_SKIP;
                    PS_ADR_LO:  st_nx = is_hex(rx_data)    ? PS_LETTER  : PS_SKIP;
                    PS_LETTER:  st_nx = is_target(rx_data) ? PS_DAT_HI  : PS_SKIP;
                    PS_DAT_HI:  st_nx = is_hex(rx_data)    ? PS_DAT_LO  : PS_SKIP;
                    PS_DAT_LO:  st_nx = is_hex(rx_data)    ? PS_WAIT_CR : PS_SKIP;
                    PS_WAIT_CR: st_nx = PS_SKIP;
                    PS_SKIP:    st_nx = PS_SKIP;
                    default:    st_nx = PS_SKIP;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_rd    <= 1'b0;
            cmd_addr  <= '0;
            cmd_idx   <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (rx_valid && is_cr) begin
                if (st == PS_WAIT_CR) begin
                    cmd_valid <= 1'b1;
                    cmd_rd    <= 1'b0;
                end else if (st == PS_DAT_HI) begin
                    cmd_valid <= 1'b1;
                    cmd_rd    <= 1'b1;
                end
            end else if (rx_valid) begin
                unique case (st)
                    PS_ADR_HI: cmd_addr[7:4] <= hex_nib(rx_data);
                    PS_ADR_LO: cmd_addr[3:0] <= hex_nib(rx_data);
                    PS_LETTER: cmd_idx       <= target_idx(rx_data);
                    PS_DAT_HI: cmd_data[7:4] <= hex_nib(rx_data);
                    PS_DAT_LO: cmd_data[3:0] <= hex_nib(rx_data);
                    default: ;
                endcase
            end
        end
    end

    // R3: a command is only issued on the cycle after a carriage return
    p_cmd_after_cr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(rx_valid && rx_data == ASC_CR));

endmodule

// File: rtl/nvpc_serial.sv
module nvpc_serial
    import nvpc_pkg::*;
#(
    parameter int HALF_DIV = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_req,
    input  logic [2:0]        sel,
    input  logic [7:0]        wdata,
    input  logic              sdi,
    output logic              sclk,
    output logic              sdo,
    output logic [NUM_NV-1:0] cs_n,
    output logic              rd_mode,
    output logic              done,
    output logic [7:0]        rdata
);

    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    typedef enum logic [1:0] {SS_IDLE, SS_LOW, SS_HIGH, SS_DONE} sst_e;

    sst_e st, st_nx;
    logic [CNT_W-1:0] div_cnt;
    logic [2:0] bit_cnt;
    logic [7:0] tx_sh, rx_sh;
    logic [2:0] sel_q;
    logic rd_q, tick, active;

    assign tick   = (div_cnt == CNT_LAST);
    assign active = (st == SS_LOW) || (st == SS_HIGH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SS_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            SS_IDLE: if (start) st_nx = SS_LOW;
            SS_LOW:  if (tick)  st_nx = SS_HIGH;
            SS_HIGH: if (tick)  st_nx = (bit_cnt == 3'd7) ? SS_DONE : SS_LOW;
            SS_DONE: st_nx = SS_IDLE;
            default: st_nx = SS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            sel_q   <= '0;
            rd_q    <= 1'b0;
        end else begin
            unique case (st)
                SS_IDLE: if (start) begin
                    tx_sh   <= wdata;
                    sel_q   <= sel;
                    rd_q    <= rd_req;
                    bit_cnt <= '0;
                    div_cnt <= '0;
                end
                SS_LOW: begin
                    div_cnt <= tick ? '0 : div_cnt + 1'b1;
                    if (tick) rx_sh <= {rx_sh[6:0], sdi};
                end
                SS_HIGH: begin
                    div_cnt <= tick ? '0 : div_cnt + 1'b1;
                    if (tick && bit_cnt != 3'd7) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        sclk    = (st == SS_HIGH);
        sdo     = active && !rd_q && tx_sh[7];
        rd_mode = active && rd_q;
        done    = (st == SS_DONE);
        rdata   = rx_sh;
        for (int i = 0; i < NUM_NV; i++) begin
            cs_n[i] = !(active && sel_q == 3'(i));
        end
    end

    // R4: never more than one part selected
    p_one_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R4: data bit held for the whole high phase of the serial clock
    p_sdo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo));
    // R4: serial clock only toggles with a part selected
    p_sclk_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> !sclk);

endmodule

// File: rtl/nvparam_cmd_ctrl.sv
module nvparam_cmd_ctrl
    import nvpc_pkg::*;
#(
    parameter int HALF_DIV = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        my_addr,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              nv_sclk,
    output logic              nv_sdo,
    input  logic              nv_sdi,
    output logic [NUM_NV-1:0] nv_cs_n,
    output logic              nv_rd,
    output logic              busy,
    output logic [7:0]        walk_w,
    output logic [7:0]        gate_w,
    output logic [7:0]        integ_k,
    output logic [7:0]        fine_gain,
    output logic [7:0]        pole_zero,
    output logic [7:0]        disc_lvl,
    output logic [1:0]        mon_sel_a,
    output logic [1:0]        mon_sel_b
);

    typedef enum logic [2:0] {
        CS_BOOT_GO, CS_BOOT_WAIT, CS_IDLE, CS_WR_WAIT, CS_TX_HI, CS_TX_LO
    } cst_e;

    cst_e cst, cst_nx;

    logic       cmd_valid, cmd_rd;
    logic [7:0] cmd_addr, cmd_data;
    logic [2:0] cmd_idx;

    logic       eng_start, eng_rd, eng_done;
    logic [2:0] eng_sel;
    logic [7:0] eng_rdata;

    logic [7:0] prm [NUM_NV];
    logic [1:0] sel_a, sel_b;
    logic [2:0] boot_idx, wr_idx;
    logic [7:0] wr_val, rd_val;
    logic       hit, acc_wr, acc_mux, acc_rd, is_nv;

    nvpc_parser u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .cmd_valid (cmd_valid),
        .cmd_rd    (cmd_rd),
        .cmd_addr  (cmd_addr),
        .cmd_idx   (cmd_idx),
        .cmd_data  (cmd_data)
    );

    nvpc_serial #(.HALF_DIV(HALF_DIV)) u_serial (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .rd_req  (eng_rd),
        .sel     (eng_sel),
        .wdata   (cmd_data),
        .sdi     (nv_sdi),
        .sclk    (nv_sclk),
        .sdo     (nv_sdo),
        .cs_n    (nv_cs_n),
        .rd_mode (nv_rd),
        .done    (eng_done),
        .rdata   (eng_rdata)
    );

    assign hit     = cmd_valid && (cmd_addr == my_addr) && (cst == CS_IDLE);
    assign is_nv   = (cmd_idx < 3'(NUM_NV));
    assign acc_wr  = hit && !cmd_rd && is_nv;
    assign acc_mux = hit && !cmd_rd && !is_nv && (cmd_data <= 8'd3);
    assign acc_rd  = hit && cmd_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cst <= CS_BOOT_GO;
        else        cst <= cst_nx;
    end

    always_comb begin
        cst_nx = cst;
        unique case (cst)
            CS_BOOT_GO:   cst_nx = CS_BOOT_WAIT;
            CS_BOOT_WAIT: if (eng_done)
                              cst_nx = (boot_idx == 3'(NUM_NV - 1)) ? CS_IDLE : CS_BOOT_GO;
            CS_IDLE:      if (acc_wr)      cst_nx = CS_WR_WAIT;
                          else if (acc_rd) cst_nx = CS_TX_HI;
            CS_WR_WAIT:   if (eng_done) cst_nx = CS_IDLE;
            CS_TX_HI:     cst_nx = CS_TX_LO;
            CS_TX_LO:     cst_nx = CS_IDLE;
            default:      cst_nx = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_NV; i++) prm[i] <= '0;
            sel_a    <= '0;
            sel_b    <= '0;
            boot_idx <= '0;
            wr_idx   <= '0;
            wr_val   <= '0;
            rd_val   <= '0;
        end else begin
            if (cst == CS_BOOT_WAIT && eng_done) begin
                prm[boot_idx] <= eng_rdata;
                boot_idx      <= boot_idx + 1'b1;
            end
            if (acc_wr) begin
                wr_idx <= cmd_idx;
                wr_val <= cmd_data;
            end
            if (cst == CS_WR_WAIT && eng_done) prm[wr_idx] <= wr_val;
            if (acc_mux) begin
                if (cmd_idx == IX_MONA) sel_a <= cmd_data[1:0];
                else                    sel_b <= cmd_data[1:0];
            end
            if (acc_rd) begin
                if (is_nv)                  rd_val <= prm[cmd_idx];
                else if (cmd_idx == IX_MONA) rd_val <= {6'd0, sel_a};
                else                        rd_val <= {6'd0, sel_b};
            end
        end
    end

    always_comb begin
        busy      = (cst != CS_IDLE);
        tx_valid  = (cst == CS_TX_HI) || (cst == CS_TX_LO);
        tx_data   = (cst == CS_TX_HI) ? nib_hex(rd_val[7:4]) :
                    (cst == CS_TX_LO) ? nib_hex(rd_val[3:0]) : 8'h00;
        eng_start = (cst == CS_BOOT_GO) || acc_wr;
        eng_rd    = (cst == CS_BOOT_GO);
        eng_sel   = (cst == CS_BOOT_GO) ? boot_idx : cmd_idx;
        walk_w    = prm[IX_WALK];
        gate_w    = prm[IX_GATE];
        integ_k   = prm[IX_INTEG];
        fine_gain = prm[IX_FINE];
        pole_zero = prm[IX_PZ];
        disc_lvl  = prm[IX_DISC];
        mon_sel_a = sel_a;
        mon_sel_b = sel_b;
    end

    // R8: any serial transfer in progress keeps busy asserted
    p_busy_in_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(&nv_cs_n) |-> busy);
    // R9: readback characters come as a pair
    p_tx_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |=> tx_valid);
    // R6: no setting moves while the controller sits idle
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cst == CS_IDLE) |=> ($stable(walk_w) && $stable(gate_w) && $stable(disc_lvl)));
    // R2: the power-up load issues only reads
    p_boot_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cst == CS_BOOT_WAIT && !(&nv_cs_n)) |-> nv_rd);

endmodule

// File: tb/sim_nvparam_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_nvparam_cmd_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] my_addr = 8'h3C;
    logic [7:0] rx_data = 8'h00;
    logic       rx_valid = 1'b0;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       nv_sclk, nv_sdo, nv_rd, busy;
    logic       nv_sdi;
    logic [5:0] nv_cs_n;
    logic [7:0] walk_w, gate_w, integ_k, fine_gain, pole_zero, disc_lvl;
    logic [1:0] mon_sel_a, mon_sel_b;

    always #10 clk = ~clk;

    nvparam_cmd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .my_addr(my_addr),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_valid(tx_valid),
        .nv_sclk(nv_sclk), .nv_sdo(nv_sdo), .nv_sdi(nv_sdi),
        .nv_cs_n(nv_cs_n), .nv_rd(nv_rd), .busy(busy),
        .walk_w(walk_w), .gate_w(gate_w), .integ_k(integ_k),
        .fine_gain(fine_gain), .pole_zero(pole_zero), .disc_lvl(disc_lvl),
        .mon_sel_a(mon_sel_a), .mon_sel_b(mon_sel_b)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]  exp_tx [$];
    logic [10:0] exp_wr [$];
    int          boot_log [$];

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // memory model: six parts, MSB-first, sampled away from the clock edge
    logic [7:0] nvm [6];
    logic [7:0] m_in, m_out;
    int         m_idx, m_bits;
    logic       m_rd, prev_sclk;
    logic [5:0] prev_cs;

    always @(negedge clk) begin
        if (!rst_n) begin
            nv_sdi = 1'b0; prev_sclk = 1'b0; prev_cs = 6'h3F;
            m_in = '0; m_out = '0; m_idx = 0; m_bits = 0; m_rd = 1'b0;
        end else begin
            if (prev_cs == 6'h3F && nv_cs_n != 6'h3F) begin
                for (int i = 0; i < 6; i++) if (!nv_cs_n[i]) m_idx = i;
                m_out = nvm[m_idx]; nv_sdi = m_out[7]; m_bits = 0;
            end else if (nv_cs_n != 6'h3F && nv_sclk && !prev_sclk) begin
                m_rd = nv_rd;
                m_in = {m_in[6:0], nv_sdo};
                m_out = {m_out[6:0], 1'b0};
                nv_sdi = m_out[7];
                m_bits++;
            end else if (prev_cs != 6'h3F && nv_cs_n == 6'h3F) begin
                if (m_rd) begin
                    boot_log.push_back(m_idx);
                end else begin
                    logic [10:0] got, want;
                    got = {3'(m_idx), m_in};
                    nvm[m_idx] = m_in;
                    if (exp_wr.size() == 0) begin
                        check(1'b0, "R4/R5/R6 unexpected serial write", int'(got), 0);
                    end else begin
                        want = exp_wr.pop_front();
                        check(got == want && m_bits == 8, "R4 serial write idx/data", int'(got), int'(want));
                    end
                end
            end
            prev_cs = nv_cs_n; prev_sclk = nv_sclk;
        end
    end

    // monitor: compare each transmitted character with the scoreboard
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (exp_tx.size() == 0) check(1'b0, "R9/R6 unexpected tx byte", int'(tx_data), 0);
            else begin
                logic [7:0] w;
                w = exp_tx.pop_front();
                check(tx_data == w, "R9 readback char", int'(tx_data), int'(w));
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); rx_data = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic send_cmd(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
        send_byte(8'h0D);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [7:0] hx(input logic [3:0] n);
        return (n < 10) ? 8'h30 + {4'h0, n} : 8'h37 + {4'h0, n};
    endfunction

    task automatic do_write(input string s, input logic [2:0] idx, input logic [7:0] v);
        exp_wr.push_back({idx, v});
        send_cmd(s);
        settle();
    endtask

    task automatic do_read(input string s, input logic [7:0] v);
        exp_tx.push_back(hx(v[7:4]));
        exp_tx.push_back(hx(v[3:0]));
        send_cmd(s);
        settle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        nvm[0] = 8'h81; nvm[1] = 8'h42; nvm[2] = 8'h24;
        nvm[3] = 8'h18; nvm[4] = 8'hC3; nvm[5] = 8'h7E;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(busy == 1'b1, "R1 busy in reset", busy, 1);
        check(nv_cs_n == 6'h3F, "R1 cs idle in reset", nv_cs_n, 'h3F);
        check(tx_valid == 1'b0, "R1 tx idle in reset", tx_valid, 0);
        check({walk_w, gate_w, disc_lvl} == 24'h0, "R1 params zero", {walk_w, gate_w, disc_lvl}, 0);
        check({mon_sel_a, mon_sel_b} == 4'h0, "R1 monitor selects zero", {mon_sel_a, mon_sel_b}, 0);
        rst_n = 1'b1;
        settle();
        // R2 power-up load
        check(walk_w == 8'h81, "R2 walk loaded", walk_w, 'h81);
        check(gate_w == 8'h42, "R2 gate loaded", gate_w, 'h42);
        check(integ_k == 8'h24, "R2 integ loaded", integ_k, 'h24);
        check(fine_gain == 8'h18, "R2 fine gain loaded", fine_gain, 'h18);
        check(pole_zero == 8'hC3, "R2 pole-zero loaded", pole_zero, 'hC3);
        check(disc_lvl == 8'h7E, "R2 disc loaded", disc_lvl, 'h7E);
        check(boot_log.size() == 6, "R2 six reads", boot_log.size(), 6);
        for (int i = 0; i < 6 && i < boot_log.size(); i++)
            check(boot_log[i] == i, "R2 read order", boot_log[i], i);

        // R3/R4 writes to every part
        do_write("3CW5A", 3'd0, 8'h5A);
        check(walk_w == 8'h5A, "R4 walk after write", walk_w, 'h5A);
        do_write("3CGB4", 3'd1, 8'hB4);
        check(gate_w == 8'hB4, "R4 gate after write", gate_w, 'hB4);
        do_write("3CI33", 3'd2, 8'h33);
        check(integ_k == 8'h33, "R4 integ after write", integ_k, 'h33);
        do_write("3CF9C", 3'd3, 8'h9C);
        check(fine_gain == 8'h9C, "R4 fine gain after write", fine_gain, 'h9C);
        do_write("3CZ07", 3'd4, 8'h07);
        check(pole_zero == 8'h07, "R4 pole-zero after write", pole_zero, 'h07);
        do_write("3CDE1", 3'd5, 8'hE1);
        check(disc_lvl == 8'hE1, "R4 disc after write", disc_lvl, 'hE1);

        // R9 readback
        do_read("3CW", 8'h5A);
        do_read("3CD", 8'hE1);

        // R7 monitor selects
        send_cmd("3CM02"); settle();
        check(mon_sel_a == 2'd2, "R7 mon A set", mon_sel_a, 2);
        send_cmd("3CN03"); settle();
        check(mon_sel_b == 2'd3, "R7 mon B set", mon_sel_b, 3);
        send_cmd("3CN07"); settle();
        check(mon_sel_b == 2'd3, "R7 mon B out of range dropped", mon_sel_b, 3);
        do_read("3CM", 8'h02);

        // R6 address filter
        send_cmd("3DGAA"); settle();
        check(gate_w == 8'hB4, "R6 other address ignored", gate_w, 'hB4);
        send_cmd("3DW"); settle();

        // R5 malformed commands
        send_cmd("3CGX1"); settle();
        send_cmd("3CQ12"); settle();
        send_cmd("3CG123"); settle();
        send_cmd("3cG12"); settle();
        send_cmd("3CG1"); settle();
        check(gate_w == 8'hB4, "R5 malformed dropped", gate_w, 'hB4);

        // R8 command during busy dropped
        exp_wr.push_back({3'd0, 8'h11});
        send_cmd("3CW11");
        @(negedge clk);
        check(busy == 1'b1, "R8 busy after accepted write", busy, 1);
        send_cmd("3CG22");
        settle();
        check(walk_w == 8'h11, "R8 first write applied", walk_w, 'h11);
        check(gate_w == 8'hB4, "R8 write during busy dropped", gate_w, 'hB4);

        check(exp_tx.size() == 0, "R9 all replies seen", exp_tx.size(), 0);
        check(exp_wr.size() == 0, "R4 all writes seen", exp_wr.size(), 0);
        check(nvm[0] == 8'h11 && nvm[1] == 8'hB4, "R4 stored values", {nvm[0], nvm[1]}, 'h11B4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule